// File: doc/BRIEF.md
# Direct-Mapped Instruction Buffer

This block places a small, fast store of instruction words between a processor's instruction-fetch port and a slower main memory that is addressed by word. Every entry holds one whole instruction word. The entry also holds a tag taken from the upper address bits and a valid flag. When a fetch arrives, the low address bits pick one entry and the stored tag is compared with the upper bits of the fetch address. On a match the word is returned one cycle later and main memory is not touched. On a mismatch the word is read from main memory through a request/acknowledge handshake. The word is then handed to the fetch port and copied into the entry with its new tag.

Data writes from the processor pass through the same block. Every write is forwarded to main memory. If the written word is currently held in the buffer, the held copy is patched in the same step, so that code which rewrites its own instructions always fetches the new value. A write to a word that is not held leaves the buffer unchanged.

The block serves one operation at a time. While a miss fill or a memory write is in flight, `busy` is high and new requests on either port are dropped. The requester retries them after `busy` falls.

Top module: `ifetch_slave_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `fetch_valid` and `mem_req` are 0. Every entry starts invalid, so the first fetch of any address after reset, including address 0, is a miss.
- R2: With default parameters, entry index = address bits [4:0] and tag = address bits [15:5]; for example, address 10259 uses entry 19 with tag 320. Filling one entry leaves every other entry unchanged.
- R3: A fetch accepted while `busy` is 0, whose entry is valid with a matching tag, gives `fetch_valid`=1 with the held word in the next cycle. No main memory request is made and `busy` stays 0.
- R4: A fetch that misses raises `mem_req`=1 and `busy`=1, with `mem_we`=0 and `mem_addr` equal to the fetch address, in the next cycle. The request holds with stable address and direction until the cycle in which `mem_ack`=1.
- R5: In the cycle after a read acknowledge, `fetch_valid`=1, `fetch_data` equals the `mem_rdata` sampled with the acknowledge, and `busy`=0. The entry is then filled, so a repeat fetch of the same address hits.
- R6: Two addresses with the same index and different tags evict each other. After a fetch of one, a fetch of the other misses.
- R7: A write accepted while `busy` is 0 raises `mem_req`=1 and `mem_we`=1 in the next cycle, with `mem_addr` and `mem_wdata` equal to the write address and data. `busy` stays 1 until the cycle after `mem_ack`.
- R8: A write to an address held in the buffer also updates the held word, so a following fetch of that address hits and returns the written value.
- R9: A write to an address not held in the buffer allocates no entry, so a following fetch of that address misses.
- R10: `fetch_req` and `wr_req` asserted while `busy` is 1 are ignored. They cause no memory access and no `fetch_valid`.
- R11: When `fetch_req` and `wr_req` are both high in an accepted cycle, the write is served and the fetch is dropped. No `fetch_valid` and no memory read result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Instruction fetch request, sampled when busy is 0 |
| fetch_addr | input | ADDR_W (16) | Fetch word address |
| wr_req | input | 1 | Data write request, sampled when busy is 0; wins over fetch_req |
| wr_addr | input | ADDR_W (16) | Write word address |
| wr_data | input | DATA_W (32) | Write data |
| busy | output | 1 | High while a fill or a memory write is in flight |
| fetch_valid | output | 1 | One-cycle pulse with the fetched word |
| fetch_data | output | DATA_W (32) | Fetched instruction word |
| mem_req | output | 1 | Main memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (16) | Main memory word address |
| mem_wdata | output | DATA_W (32) | Main memory write data |
| mem_ack | input | 1 | Main memory acknowledge, one cycle |
| mem_rdata | input | DATA_W (32) | Main memory read data, valid with mem_ack |

## Verification
The hardest case to reach is a write that lands on a word already held in the buffer and is followed by a fetch of that word. If the patch is missing, the fetch still hits, but it returns the stale word without any memory traffic to give the fault away. The stimulus first fills an entry by a miss, then writes the same address with a fresh value and fetches it again. The random phase draws addresses from a few tags over all indices, which makes such write-over-held-word events, evictions and hits frequent. Requests poked in the middle of a pending fill, and a write and fetch raised together, cover the dropped-request cases.

// File: rtl/slvbuf_pkg.sv
package slvbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } slv_state_e;

endpackage

// File: rtl/slvbuf_store.sv
module slvbuf_store #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t ent_d [DEPTH];
    entry_t ent_q [DEPTH];

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;

    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
    assign upd_idx = upd_addr[IDX_W-1:0];
    assign upd_tag = upd_addr[ADDR_W-1:IDX_W];

    assign lk_hit  = ent_q[lk_idx].valid && (ent_q[lk_idx].tag == lk_tag);
    assign lk_data = ent_q[lk_idx].data;

    // One next-value process per entry: each entry decodes its own write strobe.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_comb begin
            ent_d[e] = ent_q[e];
            if (upd_en && (upd_idx == IDX_W'(e))) begin
                ent_d[e].valid = 1'b1;
                ent_d[e].tag   = upd_tag;
                ent_d[e].data  = upd_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[e] <= '0;
            end else begin
                ent_q[e] <= ent_d[e];
            end
        end
    end

    // R5
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (lk_addr == upd_addr)) |=> (lk_addr != $past(upd_addr)) || lk_hit);

endmodule

// File: rtl/slvbuf_ctrl.sv
module slvbuf_ctrl
    import slvbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data,
    output logic              busy,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        slv_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        upd_en       = 1'b0;
        upd_addr     = ctl_q.addr;
        upd_data     = mem_rdata;
        lk_addr      = wr_req ? wr_addr : fetch_addr;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_req) begin
                    ctl_d.st    = ST_WRITE;
                    ctl_d.addr  = wr_addr;
                    ctl_d.wdata = wr_data;
                    if (lk_hit) begin
                        upd_en   = 1'b1;
                        upd_addr = wr_addr;
                        upd_data = wr_data;
                    end
                end else if (fetch_req) begin
                    if (lk_hit) begin
                        ctl_d.rvalid = 1'b1;
                        ctl_d.rdata  = lk_data;
                    end else begin
                        ctl_d.st   = ST_FILL;
                        ctl_d.addr = fetch_addr;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    upd_en       = 1'b1;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.rdata  = mem_rdata;
                    ctl_d.st     = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign mem_req     = (ctl_q.st != ST_IDLE);
    assign mem_we      = (ctl_q.st == ST_WRITE);
    assign mem_addr    = ctl_q.addr;
    assign mem_wdata   = ctl_q.wdata;
    assign fetch_valid = ctl_q.rvalid;
    assign fetch_data  = ctl_q.rdata;

    // R3
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_req && fetch_req && lk_hit) |=> (fetch_valid && !mem_req && !busy));

    // R4
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_req && fetch_req && !lk_hit) |=>
            (mem_req && !mem_we && (mem_addr == $past(fetch_addr))));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
            (fetch_valid && (fetch_data == $past(mem_rdata)) && !busy));

    // R7
    write_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req) |=> (mem_req && mem_we && (mem_wdata == $past(wr_data))));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> !fetch_valid);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req && fetch_req) |=> (!fetch_valid && mem_we));

endmodule

// File: rtl/ifetch_slave_buf.sv
module ifetch_slave_buf #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_addr;
    logic [DATA_W-1:0] upd_data;

    slvbuf_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .lk_addr     (lk_addr),
        .lk_hit      (lk_hit),
        .lk_data     (lk_data),
        .upd_en      (upd_en),
        .upd_addr    (upd_addr),
        .upd_data    (upd_data),
        .busy        (busy),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    slvbuf_store #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .upd_en   (upd_en),
        .upd_addr (upd_addr),
        .upd_data (upd_data)
    );

endmodule

// File: tb/ifetch_slave_buf_test.sv
module ifetch_slave_buf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        busy, fetch_valid, mem_req, mem_we;
    logic [31:0] fetch_data, mem_wdata;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;
    bit last_hit;

    logic [31:0] wmem [int];
    bit          exp_val [32];
    logic [10:0] exp_tag [32];

    always #2 clk = ~clk;

    ifetch_slave_buf uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(logic [15:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return {a, ~a} ^ 32'h5a3c_96e1;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Main memory responder: acks after a random wait, counts reads and writes.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                if (dly == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) wr_cnt++;
                    else begin
                        rd_cnt++;
                        mem_rdata = memval(mem_addr);
                    end
                    dly = int'($urandom % 4);
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_fetch(logic [15:0] a, bit poke);
        int idx = int'(a[4:0]);
        bit hit = exp_val[idx] && (exp_tag[idx] == a[15:5]);
        int rd0, wr0;
        wait_idle();
        rd0 = rd_cnt; wr0 = wr_cnt;
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        last_hit = fetch_valid;
        if (hit) begin
            check(fetch_valid == 1'b1, "R3", "hit valid", 32'(fetch_valid), 32'd1);
            check(fetch_data == memval(a), "R3", "hit data", fetch_data, memval(a));
            check(!busy && !mem_req, "R3", "hit no mem", 32'({busy, mem_req}), 32'd0);
            check(rd_cnt == rd0, "R3", "hit read count", 32'(rd_cnt), 32'(rd0));
        end else begin
            check(busy && mem_req && !mem_we, "R4", "miss req", 32'({busy, mem_req, mem_we}), 32'b110);
            check(mem_addr == a, "R4", "miss addr", 32'(mem_addr), 32'(a));
            if (poke) begin
                fetch_req = 1'b1; fetch_addr = a ^ 16'h0040;
                wr_req = 1'b1; wr_addr = a ^ 16'h0080; wr_data = 32'hdead_beef;
                @(negedge clk);
                fetch_req = 1'b0; wr_req = 1'b0;
            end
            for (int k = 0; k < 40 && !fetch_valid; k++) begin
                if (mem_req) check(mem_addr == a && !mem_we, "R4", "held req", 32'(mem_addr), 32'(a));
                @(negedge clk);
            end
            check(fetch_valid == 1'b1, "R5", "fill valid", 32'(fetch_valid), 32'd1);
            check(fetch_data == memval(a), "R5", "fill data", fetch_data, memval(a));
            check(!busy, "R5", "busy after fill", 32'(busy), 32'd0);
            check(rd_cnt == rd0 + 1, poke ? "R10" : "R5", "read count", 32'(rd_cnt), 32'(rd0 + 1));
            if (poke) begin
                @(negedge clk);
                check(!fetch_valid && !mem_req, "R10", "no extra activity", 32'({fetch_valid, mem_req}), 32'd0);
                check(wr_cnt == wr0, "R10", "ignored write", 32'(wr_cnt), 32'(wr0));
            end
            exp_val[idx] = 1'b1;
            exp_tag[idx] = a[15:5];
        end
    endtask

    task automatic do_write(logic [15:0] a, logic [31:0] d, bit with_fetch);
        int rd0, wr0;
        bit seen_valid = 1'b0;
        wait_idle();
        rd0 = rd_cnt; wr0 = wr_cnt;
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        if (with_fetch) begin
            fetch_req = 1'b1; fetch_addr = a ^ 16'h0100;
        end
        @(negedge clk);
        wr_req = 1'b0; fetch_req = 1'b0;
        check(mem_req && mem_we && busy, "R7", "write req", 32'({mem_req, mem_we, busy}), 32'b111);
        check(mem_addr == a, "R7", "write addr", 32'(mem_addr), 32'(a));
        check(mem_wdata == d, "R7", "write data", mem_wdata, d);
        wmem[int'(a)] = d;
        for (int k = 0; k < 40 && busy; k++) begin
            if (fetch_valid) seen_valid = 1'b1;
            @(negedge clk);
        end
        if (fetch_valid) seen_valid = 1'b1;
        check(!busy, "R7", "busy after write", 32'(busy), 32'd0);
        check(wr_cnt == wr0 + 1, "R7", "write count", 32'(wr_cnt), 32'(wr0 + 1));
        if (with_fetch) begin
            check(!seen_valid, "R11", "dropped fetch valid", 32'(seen_valid), 32'd0);
            check(rd_cnt == rd0, "R11", "dropped fetch read", 32'(rd_cnt), 32'(rd0));
        end
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 32; i++) begin exp_val[i] = 1'b0; exp_tag[i] = '0; end
        repeat (4) @(negedge clk);
        check(!busy && !fetch_valid && !mem_req, "R1", "in reset", 32'({busy, fetch_valid, mem_req}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !fetch_valid && !mem_req, "R1", "after reset", 32'({busy, fetch_valid, mem_req}), 32'd0);

        do_fetch(16'd0, 1'b0);
        check(last_hit == 1'b0, "R1", "address 0 misses", 32'(last_hit), 32'd0);
        do_fetch(16'd0, 1'b0);
        check(last_hit == 1'b1, "R3", "repeat hits", 32'(last_hit), 32'd1);

        do_fetch(16'd10259, 1'b0);
        do_fetch((16'd320 << 5) | 16'd18, 1'b0);
        do_fetch(16'd10259, 1'b0);
        check(last_hit == 1'b1, "R2", "entry 19 tag 320 kept", 32'(last_hit), 32'd1);
        do_fetch(16'd19, 1'b0);
        check(last_hit == 1'b0, "R6", "same index other tag", 32'(last_hit), 32'd0);
        do_fetch(16'd10259, 1'b0);
        check(last_hit == 1'b0, "R6", "evicted", 32'(last_hit), 32'd0);

        do_write(16'd10259, 32'h1234_abcd, 1'b0);
        do_fetch(16'd10259, 1'b0);
        check(last_hit == 1'b1, "R8", "patched hit", 32'(last_hit), 32'd1);
        check(fetch_data == 32'h1234_abcd, "R8", "patched data", fetch_data, 32'h1234_abcd);

        do_write(16'd500, 32'h0bad_cafe, 1'b0);
        do_fetch(16'd500, 1'b0);
        check(last_hit == 1'b0, "R9", "no allocate", 32'(last_hit), 32'd0);

        do_write(16'd777, 32'h5555_aaaa, 1'b1);
        do_fetch(16'd2000, 1'b1);

        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = {9'd0, 2'($urandom % 4), 5'($urandom)};
            if (($urandom % 4) == 0) do_write(a, $urandom, ($urandom % 8) == 0);
            else do_fetch(a, ($urandom % 16) == 0);
        end

        wait_idle();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule